// File: doc/BRIEF.md
# Privilege-Aware Return Stack Buffer

This block keeps one circular return-address stack per hardware thread and uses it to predict where near returns go. Each cycle it sees at most one branch event, tagged with the thread that produced it. A near call whose target differs from the address right after it pushes that fall-through address. A near return pops the top entry of its thread's stack and, one cycle later, reports either a predicted target or that the stack was empty. An empty report lets the front end use some other predictor. Far calls, far returns, interrupt returns and other events leave the stacks alone.

Every entry records two things: the predictor mode in force when it was pushed, and the thread's barrier epoch at that time. A per-thread barrier command moves the epoch forward, so every entry pushed before the barrier stops producing predictions. When a per-thread restrict control is set, an entry pushed from a less privileged mode than the current one is not allowed to predict. This check is made when the entry is popped, not when it is pushed. A filtered or stale pop still uses up its slot.

Top module: `priv_ret_stack`

## Requirements
- R1: A near call (kind code 1) with target different from pc+len pushes pc+len, and the next near return (kind code 2) on that thread reports hit=1 with that address.
- R2: A near call whose target equals pc+len (zero displacement) pushes nothing, so the stack depth of every thread is unchanged.
- R3: Far call (code 3), far return (code 4), interrupt return (code 5) and no-op (code 0) neither push nor pop, and produce no response.
- R4: Returns on one thread predict that thread's pushed addresses in last-in, first-out order.
- R5: A near return on a thread with zero live entries reports empty=1, hit=0, address 0, and it does not move the stack pointer.
- R6: The depth is 32. After 33 qualifying pushes, 32 returns give the newest 32 addresses newest-first, and the next return reports empty.
- R7: After a barrier on a thread, a pop of an entry pushed before the barrier reports hit=0 and empty=0 and consumes that entry. Entries pushed after the barrier predict normally. If a branch and a barrier arrive in the same cycle, the branch is ordered first.
- R8: A barrier on one thread does not affect predictions from another thread's entries.
- R9: Mode encoding is {host, supervisor}, ordered 3 > 2 > 1 > 0. With restrict set on the popping thread, an entry whose mode is below that thread's current mode gives hit=0, even if restrict was raised after the push. Entries at an equal or higher mode still hit.
- R10: With restrict clear, an entry pushed from a lower mode still predicts.
- R11: Each thread has its own stack, pointer and count; activity on one thread never changes another thread's predictions.
- R12: A response (rsp_valid_o=1, rsp_tid_o = thread) appears exactly in the cycle after a near return is accepted, and no response appears after any other event.
- R13: After reset all stacks are empty and rsp_valid_o, rsp_hit_o, rsp_empty_o are 0.
- R14: After 16 or more barriers (a full epoch wrap), entries pushed before them still never predict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| br_valid_i | input | 1 | Branch event present this cycle |
| br_kind_i | input | 3 | Event kind: 0 none, 1 near call, 2 near return, 3 far call, 4 far return, 5 interrupt return |
| br_tid_i | input | TID_W | Thread of the event |
| br_pc_i | input | ADDR_W | Address of the branch instruction |
| br_len_i | input | LEN_W | Length of the branch instruction |
| br_target_i | input | ADDR_W | Resolved target of a call |
| mode_i | input | 2*NUM_THREADS | Current predictor mode per thread, 2 bits each |
| restrict_i | input | NUM_THREADS | Per-thread restrict control |
| barrier_i | input | NUM_THREADS | Per-thread barrier command, one-cycle pulse |
| rsp_valid_o | output | 1 | Return response valid |
| rsp_tid_o | output | TID_W | Thread of the response |
| rsp_hit_o | output | 1 | Prediction available |
| rsp_empty_o | output | 1 | Stack had no live entries |
| rsp_addr_o | output | ADDR_W | Predicted return address, 0 when no hit |

## Verification
The properties assume that an event's thread id is below the thread count and that its kind is one of the six defined codes. They also assume that pc+len wraps modulo the address width. Given those, the push and pop count checks and the response-timing checks are meaningful. The stimulus always draws thread ids from the valid range and kinds from the defined codes. It uses random pc and length values, and in most calls the target is either exactly pc+len or a random address. It also moves modes, restrict and barriers at random, so filtering and epoch changes occur in the middle of stack traffic.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [2:0] {
    BR_NONE      = 3'd0,
    BR_NEAR_CALL = 3'd1,
    BR_NEAR_RET  = 3'd2,
    BR_FAR_CALL  = 3'd3,
    BR_FAR_RET   = 3'd4,
    BR_IRET      = 3'd5
  } br_kind_e;

  // {host, supervisor}: numerically larger = more privileged
  typedef logic [1:0] pmode_t;

  function automatic logic mode_below(input pmode_t entry_m, input pmode_t cur_m);
    return entry_m < cur_m;
  endfunction
endpackage

// File: rtl/prs_branch_decode.sv
module prs_branch_decode
  import prs_pkg::*;
#(
  parameter int NT     = 2,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int TID_W  = 1
) (
  input  logic              valid_i,
  input  logic [2:0]        kind_i,
  input  logic [TID_W-1:0]  tid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [NT-1:0]     push_o,
  output logic [NT-1:0]     pop_o,
  output logic [ADDR_W-1:0] push_addr_o
);
  logic near_call, near_ret, nonzero_disp;

  assign push_addr_o  = pc_i + ADDR_W'(len_i);
  assign nonzero_disp = target_i != push_addr_o;
  assign near_call    = valid_i && (kind_i == BR_NEAR_CALL) && nonzero_disp;
  assign near_ret     = valid_i && (kind_i == BR_NEAR_RET);

  for (genvar t = 0; t < NT; t++) begin : g_sel
    assign push_o[t] = near_call && (tid_i == TID_W'(t));
    assign pop_o[t]  = near_ret  && (tid_i == TID_W'(t));
  end
endmodule

// File: rtl/prs_tag_check.sv
module prs_tag_check
  import prs_pkg::*;
#(
  parameter int EPOCH_W = 4
) (
  input  logic               entry_vld_i,
  input  logic [EPOCH_W-1:0] entry_epoch_i,
  input  logic [EPOCH_W-1:0] cur_epoch_i,
  input  pmode_t             entry_mode_i,
  input  pmode_t             cur_mode_i,
  input  logic               restrict_i,
  output logic               usable_o
);
  logic same_epoch, mode_blocked;

  assign same_epoch   = entry_epoch_i == cur_epoch_i;
  assign mode_blocked = restrict_i && mode_below(entry_mode_i, cur_mode_i);
  assign usable_o     = entry_vld_i && same_epoch && !mode_blocked;
endmodule

// File: rtl/prs_thread_stack.sv
module prs_thread_stack
  import prs_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int ADDR_W  = 32,
  parameter int EPOCH_W = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  pmode_t            cur_mode_i,
  input  logic              restrict_i,
  input  logic              barrier_i,
  output logic              top_hit_o,
  output logic              top_empty_o,
  output logic [ADDR_W-1:0] top_addr_o,
  output pmode_t            top_mode_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0]   FULL       = CNT_W'(DEPTH);
  localparam logic [EPOCH_W-1:0] EPOCH_LAST = '1;

  logic [ADDR_W-1:0]  addr_q [DEPTH];
  pmode_t             mode_q [DEPTH];
  logic [EPOCH_W-1:0] tag_q  [DEPTH];
  logic [DEPTH-1:0]   vld_q;
  logic [PTR_W-1:0]   ptr_q, top_idx;
  logic [CNT_W-1:0]   cnt_q;
  logic [EPOCH_W-1:0] epoch_q;
  logic               scrub, usable, do_pop;

  assign top_idx     = ptr_q - PTR_W'(1);
  assign top_empty_o = cnt_q == '0;
  assign top_addr_o  = addr_q[top_idx];
  assign top_mode_o  = mode_q[top_idx];
  assign count_o     = cnt_q;
  // epoch wraps: wipe valid bits so old tags can never alias
  assign scrub       = barrier_i && (epoch_q == EPOCH_LAST);
  assign do_pop      = pop_i && !top_empty_o;

  prs_tag_check #(.EPOCH_W(EPOCH_W)) u_tag (
    .entry_vld_i  (vld_q[top_idx]),
    .entry_epoch_i(tag_q[top_idx]),
    .cur_epoch_i  (epoch_q),
    .entry_mode_i (mode_q[top_idx]),
    .cur_mode_i   (cur_mode_i),
    .restrict_i   (restrict_i),
    .usable_o     (usable)
  );
  assign top_hit_o = !top_empty_o && usable;

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[ptr_q] <= push_addr_i;
      mode_q[ptr_q] <= cur_mode_i;
      tag_q[ptr_q]  <= epoch_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      epoch_q <= '0;
    end else begin
      if (scrub)       vld_q        <= '0;
      else if (push_i) vld_q[ptr_q] <= 1'b1;
      if (push_i) begin
        ptr_q <= ptr_q + PTR_W'(1);
        if (cnt_q != FULL) cnt_q <= cnt_q + CNT_W'(1);
      end else if (do_pop) begin
        ptr_q <= top_idx;
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (barrier_i) epoch_q <= epoch_q + EPOCH_W'(1);
    end
  end
endmodule

// File: rtl/priv_ret_stack.sv
module priv_ret_stack
  import prs_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 32,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 4,
  parameter int EPOCH_W     = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     br_valid_i,
  input  logic [2:0]               br_kind_i,
  input  logic [TID_W-1:0]         br_tid_i,
  input  logic [ADDR_W-1:0]        br_pc_i,
  input  logic [LEN_W-1:0]         br_len_i,
  input  logic [ADDR_W-1:0]        br_target_i,
  input  logic [2*NUM_THREADS-1:0] mode_i,
  input  logic [NUM_THREADS-1:0]   restrict_i,
  input  logic [NUM_THREADS-1:0]   barrier_i,
  output logic                     rsp_valid_o,
  output logic [TID_W-1:0]         rsp_tid_o,
  output logic                     rsp_hit_o,
  output logic                     rsp_empty_o,
  output logic [ADDR_W-1:0]        rsp_addr_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NUM_THREADS-1:0]       push_v, pop_v, hit_v, empty_v;
  logic [ADDR_W-1:0]            push_addr;
  logic [ADDR_W-1:0]            top_addr [NUM_THREADS];
  pmode_t                       top_mode [NUM_THREADS];
  logic [NUM_THREADS*CNT_W-1:0] cnt_all;
  logic                         sel_hit, sel_empty, ret_any;
  logic [ADDR_W-1:0]            sel_addr;
  pmode_t                       sel_mode, rsp_mode_q;

  prs_branch_decode #(
    .NT(NUM_THREADS), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TID_W(TID_W)
  ) u_dec (
    .valid_i    (br_valid_i),
    .kind_i     (br_kind_i),
    .tid_i      (br_tid_i),
    .pc_i       (br_pc_i),
    .len_i      (br_len_i),
    .target_i   (br_target_i),
    .push_o     (push_v),
    .pop_o      (pop_v),
    .push_addr_o(push_addr)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    prs_thread_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W)) u_stk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push_v[t]),
      .pop_i      (pop_v[t]),
      .push_addr_i(push_addr),
      .cur_mode_i (mode_i[2*t +: 2]),
      .restrict_i (restrict_i[t]),
      .barrier_i  (barrier_i[t]),
      .top_hit_o  (hit_v[t]),
      .top_empty_o(empty_v[t]),
      .top_addr_o (top_addr[t]),
      .top_mode_o (top_mode[t]),
      .count_o    (cnt_all[t*CNT_W +: CNT_W])
    );
  end

  assign ret_any = |pop_v;

  always_comb begin
    sel_hit   = 1'b0;
    sel_empty = 1'b0;
    sel_addr  = '0;
    sel_mode  = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (br_tid_i == TID_W'(t)) begin
        sel_hit   = hit_v[t];
        sel_empty = empty_v[t];
        sel_addr  = top_addr[t];
        sel_mode  = top_mode[t];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_tid_o   <= '0;
      rsp_hit_o   <= 1'b0;
      rsp_empty_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_mode_q  <= '0;
    end else begin
      rsp_valid_o <= ret_any;
      rsp_tid_o   <= br_tid_i;
      rsp_hit_o   <= ret_any && sel_hit;
      rsp_empty_o <= ret_any && sel_empty;
      rsp_addr_o  <= (ret_any && sel_hit) ? sel_addr : '0;
      rsp_mode_q  <= sel_mode;
    end
  end
endmodule

// File: rtl/prs_checker.sv
module prs_checker
  import prs_pkg::*;
#(
  parameter int NT     = 2,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int TID_W  = 1,
  parameter int CNT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              br_valid_i,
  input logic [2:0]        br_kind_i,
  input logic [TID_W-1:0]  br_tid_i,
  input logic [ADDR_W-1:0] br_pc_i,
  input logic [LEN_W-1:0]  br_len_i,
  input logic [ADDR_W-1:0] br_target_i,
  input logic [2*NT-1:0]   mode_i,
  input logic [NT-1:0]     restrict_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_empty_o,
  input logic [NT*CNT_W-1:0] cnt_all,
  input pmode_t            rsp_mode_q
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  function automatic logic [CNT_W-1:0] cnt_of(input logic [TID_W-1:0] t);
    logic [CNT_W-1:0] r;
    r = '0;
    for (int i = 0; i < NT; i++) if (t == TID_W'(i)) r = cnt_all[i*CNT_W +: CNT_W];
    return r;
  endfunction

  logic tid_ok, is_ret, is_far, is_call, zero_disp;
  logic last_push_q, cap_restrict_q;
  logic [TID_W-1:0] last_tid_q;
  logic [CNT_W-1:0] last_cnt_q;
  pmode_t cap_mode_q, cur_mode;

  assign tid_ok    = int'(br_tid_i) < NT;
  assign zero_disp = br_target_i == (br_pc_i + ADDR_W'(br_len_i));
  assign is_call   = br_valid_i && tid_ok && br_kind_i == BR_NEAR_CALL;
  assign is_ret    = br_valid_i && tid_ok && br_kind_i == BR_NEAR_RET;
  assign is_far    = br_valid_i && (br_kind_i == BR_FAR_CALL || br_kind_i == BR_FAR_RET ||
                                    br_kind_i == BR_IRET);

  always_comb begin
    cur_mode = '0;
    for (int i = 0; i < NT; i++) if (br_tid_i == TID_W'(i)) cur_mode = mode_i[2*i +: 2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_push_q    <= 1'b0;
      last_tid_q     <= '0;
      last_cnt_q     <= '0;
      cap_restrict_q <= 1'b0;
      cap_mode_q     <= '0;
    end else begin
      last_push_q    <= is_call && !zero_disp;
      last_tid_q     <= br_tid_i;
      last_cnt_q     <= cnt_of(br_tid_i);
      cap_restrict_q <= is_ret && restrict_i[br_tid_i];
      cap_mode_q     <= cur_mode;
    end
  end

  a_r1_push_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_push_q && last_cnt_q != FULL) |-> cnt_of(last_tid_q) == last_cnt_q + CNT_W'(1));
  a_r6_count_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_push_q && last_cnt_q == FULL) |-> cnt_of(last_tid_q) == FULL);
  a_r2_zero_disp_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_call && zero_disp) |=> $stable(cnt_all));
  a_r3_far_leaves_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_far |=> $stable(cnt_all));
  a_r12_rsp_after_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ret |=> rsp_valid_o);
  a_r12_no_rsp_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ret |=> !rsp_valid_o);
  a_r5_empty_excludes_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_empty_o |-> !rsp_hit_o);
  a_r9_restrict_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_hit_o && cap_restrict_q) |-> !mode_below(rsp_mode_q, cap_mode_q));
endmodule

bind priv_ret_stack prs_checker #(
  .NT(NUM_THREADS), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
  .TID_W(TID_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .br_valid_i (br_valid_i),
  .br_kind_i  (br_kind_i),
  .br_tid_i   (br_tid_i),
  .br_pc_i    (br_pc_i),
  .br_len_i   (br_len_i),
  .br_target_i(br_target_i),
  .mode_i     (mode_i),
  .restrict_i (restrict_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o  (rsp_hit_o),
  .rsp_empty_o(rsp_empty_o),
  .cnt_all    (cnt_all),
  .rsp_mode_q (rsp_mode_q)
);

// File: tb/priv_ret_stack_tb_top.sv
`timescale 1ns/1ps
module priv_ret_stack_tb_top;
  localparam int NT = 2;
  localparam int D  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [2:0]  br_kind = '0;
  logic [0:0]  br_tid = '0;
  logic [31:0] br_pc = '0, br_target = '0;
  logic [3:0]  br_len = '0;
  logic [3:0]  mode_v = '0;
  logic [1:0]  restrict_v = '0, barrier_v = '0;
  logic        rsp_valid, rsp_hit, rsp_empty;
  logic [0:0]  rsp_tid;
  logic [31:0] rsp_addr;

  int errors = 0, checks = 0;

  priv_ret_stack dut_i (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(br_valid), .br_kind_i(br_kind),
    .br_tid_i(br_tid), .br_pc_i(br_pc), .br_len_i(br_len), .br_target_i(br_target),
    .mode_i(mode_v), .restrict_i(restrict_v), .barrier_i(barrier_v),
    .rsp_valid_o(rsp_valid), .rsp_tid_o(rsp_tid), .rsp_hit_o(rsp_hit),
    .rsp_empty_o(rsp_empty), .rsp_addr_o(rsp_addr)
  );

  always #2.5 clk = ~clk;

  // reference model
  logic [31:0] m_addr [NT][D];
  logic [1:0]  m_mode [NT][D];
  int          m_gen  [NT][D];
  int          m_ptr [NT], m_cnt [NT], m_cur [NT];

  function automatic void model_reset();
    for (int t = 0; t < NT; t++) begin
      m_ptr[t] = 0; m_cnt[t] = 0; m_cur[t] = 0;
      for (int i = 0; i < D; i++) begin m_gen[t][i] = -1; m_addr[t][i] = '0; m_mode[t][i] = '0; end
    end
  endfunction

  task automatic step(input logic [2:0] kind, input int tid, input logic [31:0] pc,
                      input logic [3:0] len, input logic [31:0] tgt,
                      input logic [1:0] bar, input string tag);
    logic e_valid, e_hit, e_empty, ok;
    logic [31:0] e_addr, nxt;
    int idx;
    e_valid = 1'b0; e_hit = 1'b0; e_empty = 1'b0; e_addr = '0;
    nxt = pc + {28'd0, len};
    if (kind == 3'd2) begin
      e_valid = 1'b1;
      if (m_cnt[tid] == 0) e_empty = 1'b1;
      else begin
        idx = (m_ptr[tid] + D - 1) % D;
        e_hit = (m_gen[tid][idx] == m_cur[tid]) &&
                !(restrict_v[tid] && (m_mode[tid][idx] < mode_v[2*tid +: 2]));
        if (e_hit) e_addr = m_addr[tid][idx];
        m_ptr[tid] = idx;
        m_cnt[tid] = m_cnt[tid] - 1;
      end
    end else if (kind == 3'd1 && tgt != nxt) begin
      idx = m_ptr[tid];
      m_addr[tid][idx] = nxt;
      m_mode[tid][idx] = mode_v[2*tid +: 2];
      m_gen[tid][idx]  = m_cur[tid];
      m_ptr[tid] = (idx + 1) % D;
      if (m_cnt[tid] < D) m_cnt[tid] = m_cnt[tid] + 1;
    end
    for (int t = 0; t < NT; t++) if (bar[t]) m_cur[t] = m_cur[t] + 1;

    br_valid = kind != 3'd0; br_kind = kind; br_tid = 1'(tid);
    br_pc = pc; br_len = len; br_target = tgt; barrier_v = bar;
    @(negedge clk);
    br_valid = 1'b0; barrier_v = '0;
    // R12: response only in the cycle after a near return
    ok = (rsp_valid == e_valid) && (rsp_hit == e_hit) && (rsp_empty == e_empty) &&
         (rsp_addr == e_addr) && (!e_valid || rsp_tid == 1'(tid));
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got v=%0b t=%0d h=%0b e=%0b a=%h exp v=%0b t=%0d h=%0b e=%0b a=%h",
               tag, rsp_valid, rsp_tid, rsp_hit, rsp_empty, rsp_addr,
               e_valid, tid, e_hit, e_empty, e_addr);
    end
  endtask

  task automatic call(input int tid, input logic [31:0] pc, input string tag);
    step(3'd1, tid, pc, 4'd5, pc + 32'h100, 2'b00, tag);
  endtask
  task automatic ret(input int tid, input string tag);
    step(3'd2, tid, 32'h0, 4'd1, 32'h0, 2'b00, tag);
  endtask
  task automatic barrier(input logic [1:0] b, input string tag);
    step(3'd0, 0, 32'h0, 4'd1, 32'h0, b, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0] k;
    logic [31:0] pc;
    logic [3:0] ln;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid || rsp_hit || rsp_empty) begin
      errors++;
      $display("FAIL R13 reset: v=%0b h=%0b e=%0b exp 0 0 0", rsp_valid, rsp_hit, rsp_empty);
    end
    rst_n = 1'b1;
    @(negedge clk);

    ret(0, "R13 empty after reset");
    ret(0, "R5 empty pop");
    call(0, 32'h1000, "R1 push");
    ret(0, "R1 predict pc+len");
    ret(0, "R5 empty again");
    step(3'd1, 0, 32'h2000, 4'd3, 32'h2003, 2'b00, "R2 zero disp");
    ret(0, "R2 nothing pushed");
    for (int i = 0; i < 3; i++) call(0, 32'h3000 + 32'(i) * 32'h40, "R4 push");
    for (int i = 0; i < 3; i++) ret(0, "R4 lifo");
    call(0, 32'h4000, "R3 setup");
    step(3'd3, 0, 32'h4100, 4'd7, 32'h9000, 2'b00, "R3 far call");
    step(3'd4, 0, 32'h4200, 4'd1, 32'h0, 2'b00, "R3 far ret");
    step(3'd5, 0, 32'h4300, 4'd2, 32'h0, 2'b00, "R3 iret");
    step(3'd0, 0, 32'h4400, 4'd2, 32'h0, 2'b00, "R12 idle");
    ret(0, "R3 entry survives");
    ret(0, "R3 no extra entry");
    call(0, 32'h5000, "R11 t0");
    call(1, 32'h6000, "R11 t1");
    ret(0, "R11 t0 own");
    ret(1, "R11 t1 own");
    for (int i = 0; i < 33; i++) call(0, 32'h7000 + 32'(i) * 32'h10, "R6 fill");
    for (int i = 0; i < 33; i++) ret(0, "R6 drain");
    call(0, 32'h8000, "R7 old");
    barrier(2'b01, "R7 barrier");
    call(0, 32'h8100, "R7 new");
    ret(0, "R7 new hits");
    ret(0, "R7 old stale");
    ret(0, "R7 then empty");
    call(1, 32'h8200, "R8 t1");
    barrier(2'b01, "R8 barrier t0");
    ret(1, "R8 t1 unaffected");
    call(0, 32'h8300, "R14 old");
    for (int i = 0; i < 16; i++) barrier(2'b01, "R14 wrap");
    ret(0, "R14 still stale");
    mode_v = 4'b0000; restrict_v = 2'b00;
    call(0, 32'h9000, "R9 guest user push");
    mode_v = 4'b0011; restrict_v = 2'b01;
    ret(0, "R9 lower blocked after late restrict");
    call(0, 32'h9100, "R9 equal push");
    ret(0, "R9 equal hits");
    call(0, 32'h9200, "R9 high push");
    mode_v = 4'b0010;
    ret(0, "R9 higher entry hits");
    mode_v = 4'b0001; restrict_v = 2'b00;
    call(0, 32'h9300, "R10 push");
    mode_v = 4'b0011;
    ret(0, "R10 unrestricted hits");

    for (int i = 0; i < 4000; i++) begin
      int tid, r;
      logic [1:0] b;
      tid = int'($urandom_range(1, 0));
      r = int'($urandom_range(99, 0));
      pc = $urandom;
      ln = 4'($urandom_range(15, 1));
      if (r < 45) k = 3'd1; else if (r < 85) k = 3'd2; else k = 3'($urandom_range(5, 3));
      b = ($urandom_range(99, 0) < 3) ? 2'($urandom_range(3, 1)) : 2'b00;
      if ($urandom_range(9, 0) == 0) mode_v = 4'($urandom);
      if ($urandom_range(9, 0) == 0) restrict_v = 2'($urandom);
      step(k, tid, pc, ln, ($urandom_range(9, 0) == 0) ? pc + {28'd0, ln} : $urandom, b,
           "R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule